// File: doc/BRIEF.md
# Two-Level Carry-Lookahead Adder

This block is a purely combinational 16-bit binary adder. It takes two operands and a carry-in, and it returns a 16-bit sum and a carry-out. It is intended for a datapath where the adder sits between pipeline registers owned by the surrounding logic. Carry-lookahead is used at two levels so that no carry ripples from bit to bit or from slice to slice.

The operand width is cut into four 4-bit slices. Each slice forms a generate and a propagate term for every bit position. From those terms it computes its own internal carries in parallel, as flat sums of products. Each slice also reports one group generate and one group propagate. A second lookahead unit applies the same sum-of-products form to the four group pairs and the adder carry-in. It yields the carry into every slice and the final carry-out.

There is no clock, no handshake and no state. The outputs follow the inputs after the combinational delay, so no valid/ready interface is used and no back-pressure rules apply.

Top module: `cla16_adder`

## Requirements
- R1: `sum` equals the low 16 bits of the unsigned value `a + b + cin`, for every input combination.
- R2: `cout` equals bit 16 of the 17-bit unsigned value `a + b + cin`.
- R3: When every bit position has exactly one operand bit set (`a ^ b` all ones, `a & b` zero), the carry travels the full width: `sum` is all ones and `cout` is 0 for `cin` = 0, and `sum` is zero and `cout` is 1 for `cin` = 1.
- R4: For slice k (bits 4k to 4k+3, k = 1..3), the carry into bit 4k equals bit 4k of `(a mod 2^4k) + (b mod 2^4k) + cin`. This carry is visible at the ports as `sum[4k] ^ a[4k] ^ b[4k]`.
- R5: A slice whose two 4-bit operand fields add to 16 or more produces a carry into the next slice (or `cout` for the top slice), whatever carry it receives. A slice whose fields add to 15 or less, with no incoming carry, produces none.
- R6: A slice whose operand fields cover every bit position with exactly one set bit passes its incoming carry unchanged to the next slice (or to `cout` for the top slice).
- R7: At the extremes, `FFFF + FFFF + 1` gives `sum` = FFFF and `cout` = 1, and `FFFF + FFFF + 0` gives `sum` = FFFE and `cout` = 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a | input | 16 | First addend |
| b | input | 16 | Second addend |
| cin | input | 1 | Carry into bit 0 |
| sum | output | 16 | Sum bits 0 to 15 |
| cout | output | 1 | Carry out of bit 15 |

## Verification
The bench builds the adder with its default parameters: four slices of four bits each. It sweeps all 512 operand and carry-in combinations of each slice in turn. While doing so, it holds the other slices at three backgrounds: all zero, an all-propagate chain, and all-generate. This reaches every generate, propagate and kill pattern a slice can present to the second level, together with each carry value arriving from below. Directed full-width propagate chains and the all-ones extremes cover the longest carry paths. A long run of random operand pairs then samples the rest of the 33-bit input space against an arithmetic reference.

// File: rtl/cla_pkg.sv
package cla_pkg;
  localparam int CLA_SLICE_W = 4;
  localparam int CLA_SLICES  = 4;

  typedef struct packed {
    logic gen;
    logic prop;
  } grp_sig_t;
endpackage

// File: rtl/cla_lookahead.sv
// Flat sum-of-products carry lookahead over N generate/propagate pairs.
// carry[k] = OR over j<k of (gen[j] AND prop[j+1..k-1]) OR (c_in AND prop[0..k-1]).
module cla_lookahead #(
  parameter int N = 4
) (
  input  logic [N-1:0] gen,
  input  logic [N-1:0] prop,
  input  logic         c_in,
  output logic [N:0]   carry,
  output logic         grp_gen,
  output logic         grp_prop
);
  always_comb begin
    logic acc;
    logic term;
    carry[0] = c_in;
    for (int k = 1; k <= N; k++) begin
      acc = 1'b0;
      for (int j = 0; j < k; j++) begin
        term = gen[j];
        for (int m = j + 1; m < k; m++) term = term & prop[m];
        acc = acc | term;
      end
      term = c_in;
      for (int m = 0; m < k; m++) term = term & prop[m];
      carry[k] = acc | term;
    end
  end

  // Group terms: generate-only part of the top carry, and the full propagate product.
  always_comb begin
    logic acc;
    logic term;
    acc = 1'b0;
    for (int j = 0; j < N; j++) begin
      term = gen[j];
      for (int m = j + 1; m < N; m++) term = term & prop[m];
      acc = acc | term;
    end
    grp_gen = acc;
  end

  assign grp_prop = &prop;
endmodule

// File: rtl/cla_slice.sv
// One slice: bit-level generate/propagate, internal lookahead, sum bits.
module cla_slice #(
  parameter int W = 4
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         c_in,
  output logic [W-1:0] sum,
  output logic         c_out,
  output logic         grp_gen,
  output logic         grp_prop
);
  logic [W-1:0] bit_gen;
  logic [W-1:0] bit_prop;
  logic [W:0]   carry;

  assign bit_gen  = a & b;
  assign bit_prop = a | b;

  cla_lookahead #(.N(W)) u_bits (
    .gen      (bit_gen),
    .prop     (bit_prop),
    .c_in     (c_in),
    .carry    (carry),
    .grp_gen  (grp_gen),
    .grp_prop (grp_prop)
  );

  assign sum   = a ^ b ^ carry[W-1:0];
  assign c_out = carry[W];
endmodule

// File: rtl/cla16_adder.sv
module cla16_adder
  import cla_pkg::*;
#(
  parameter int SLICE_W  = CLA_SLICE_W,
  parameter int N_SLICES = CLA_SLICES
) (
  input  logic [SLICE_W*N_SLICES-1:0] a,
  input  logic [SLICE_W*N_SLICES-1:0] b,
  input  logic                        cin,
  output logic [SLICE_W*N_SLICES-1:0] sum,
  output logic                        cout
);
  localparam int W = SLICE_W * N_SLICES;

  grp_sig_t [N_SLICES-1:0] grp;
  logic [N_SLICES-1:0]     grp_gen;
  logic [N_SLICES-1:0]     grp_prop;
  logic [N_SLICES-1:0]     slice_cout;
  logic [N_SLICES:0]       lk_carry;
  logic                    top_gen;
  logic                    top_prop;

  for (genvar s = 0; s < N_SLICES; s++) begin : g_slice
    cla_slice #(.W(SLICE_W)) u_slice (
      .a        (a[s*SLICE_W +: SLICE_W]),
      .b        (b[s*SLICE_W +: SLICE_W]),
      .c_in     (lk_carry[s]),
      .sum      (sum[s*SLICE_W +: SLICE_W]),
      .c_out    (slice_cout[s]),
      .grp_gen  (grp[s].gen),
      .grp_prop (grp[s].prop)
    );
    assign grp_gen[s]  = grp[s].gen;
    assign grp_prop[s] = grp[s].prop;
  end

  cla_lookahead #(.N(N_SLICES)) u_groups (
    .gen      (grp_gen),
    .prop     (grp_prop),
    .c_in     (cin),
    .carry    (lk_carry),
    .grp_gen  (top_gen),
    .grp_prop (top_prop)
  );

  assign cout = lk_carry[N_SLICES];
endmodule

// File: rtl/cla16_checker.sv
module cla16_checker #(
  parameter int SLICE_W  = 4,
  parameter int N_SLICES = 4
) (
  input logic [SLICE_W*N_SLICES-1:0] a,
  input logic [SLICE_W*N_SLICES-1:0] b,
  input logic                        cin,
  input logic [SLICE_W*N_SLICES-1:0] sum,
  input logic                        cout,
  input logic [N_SLICES:0]           lk_carry,
  input logic [N_SLICES-1:0]         slice_cout,
  input logic [N_SLICES-1:0]         grp_gen,
  input logic [N_SLICES-1:0]         grp_prop,
  input logic                        top_gen,
  input logic                        top_prop
);
  localparam int W = SLICE_W * N_SLICES;

  always_comb begin
    logic [W:0]       ref_sum;
    logic [W:0]       mask;
    logic [W:0]       lo_sum;
    logic [SLICE_W:0] nib_sum;
    ref_sum = {1'b0, a} + {1'b0, b} + {{W{1'b0}}, cin};
    assert_sum_R1: assert (sum == ref_sum[W-1:0]);
    assert_cout_R2: assert (cout == ref_sum[W]);
    if (((a ^ b) == {W{1'b1}}) && ((a & b) == '0))
      assert_chain_R3: assert ((sum == {W{~cin}}) && (cout == cin));
    for (int k = 0; k <= N_SLICES; k++) begin
      mask   = ({{W{1'b0}}, 1'b1} << (k * SLICE_W)) - 1'b1;
      lo_sum = {1'b0, a & mask[W-1:0]} + {1'b0, b & mask[W-1:0]} + {{W{1'b0}}, cin};
      assert_slice_carry_R4: assert (lk_carry[k] == lo_sum[k*SLICE_W]);
    end
    for (int k = 0; k < N_SLICES; k++) begin
      nib_sum = {1'b0, a[k*SLICE_W +: SLICE_W]} + {1'b0, b[k*SLICE_W +: SLICE_W]};
      assert_group_gen_R5: assert (grp_gen[k] == nib_sum[SLICE_W]);
      assert_group_prop_R6: assert (grp_prop[k] == &(a[k*SLICE_W +: SLICE_W] | b[k*SLICE_W +: SLICE_W]));
      assert_slice_cout_R4: assert (slice_cout[k] == lk_carry[k+1]);
    end
    assert_top_group_R2: assert ((top_gen | (top_prop & cin)) == cout);
  end
endmodule

bind cla16_adder cla16_checker #(.SLICE_W(SLICE_W), .N_SLICES(N_SLICES)) u_check (
  .a          (a),
  .b          (b),
  .cin        (cin),
  .sum        (sum),
  .cout       (cout),
  .lk_carry   (lk_carry),
  .slice_cout (slice_cout),
  .grp_gen    (grp_gen),
  .grp_prop   (grp_prop),
  .top_gen    (top_gen),
  .top_prop   (top_prop)
);

// File: tb/tb_cla16_adder.sv
module tb_cla16_adder;
  localparam int CLK_PERIOD = 10;
  localparam int W = 16;

  logic clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic [W-1:0] a = '0;
  logic [W-1:0] b = '0;
  logic         cin = 1'b0;
  logic [W-1:0] sum;
  logic         cout;
  int n_tests = 0;
  int n_fail  = 0;

  cla16_adder dut (.a(a), .b(b), .cin(cin), .sum(sum), .cout(cout));

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s a=%h b=%h cin=%0d actual=%h expected=%h", req, a, b, cin, act, exp);
    end
  endtask

  // Drive on the rising edge, sample on the falling edge.
  task automatic apply(input logic [W-1:0] av, input logic [W-1:0] bv, input logic cv);
    @(posedge clk);
    a = av; b = bv; cin = cv;
    @(negedge clk);
  endtask

  task automatic full_check(input logic [W-1:0] av, input logic [W-1:0] bv, input logic cv);
    logic [W:0] ref_sum;
    logic [W:0] mask;
    logic [W:0] lo_sum;
    apply(av, bv, cv);
    ref_sum = {1'b0, av} + {1'b0, bv} + {{W{1'b0}}, cv};
    check("R1 sum", {16'h0, sum}, {16'h0, ref_sum[W-1:0]});
    check("R2 cout", {31'h0, cout}, {31'h0, ref_sum[W]});
    for (int k = 1; k < 4; k++) begin
      mask   = ({{W{1'b0}}, 1'b1} << (4 * k)) - 1'b1;
      lo_sum = {1'b0, av & mask[W-1:0]} + {1'b0, bv & mask[W-1:0]} + {{W{1'b0}}, cv};
      check("R4 slice carry", {31'h0, sum[4*k] ^ av[4*k] ^ bv[4*k]}, {31'h0, lo_sum[4*k]});
    end
  endtask

  // Carry leaving slice k: next slice's bit 0 (operands zero there) or cout.
  function automatic logic carry_after(input int k);
    return (k == 3) ? cout : sum[4*(k+1)];
  endfunction

  initial begin
    logic [W-1:0] bg_a [3];
    logic [W-1:0] bg_b [3];
    logic [W-1:0] keep;
    logic [W-1:0] av;
    logic [W-1:0] bv;
    bg_a[0] = 16'h0000; bg_b[0] = 16'h0000;
    bg_a[1] = 16'hAAAA; bg_b[1] = 16'h5555;
    bg_a[2] = 16'hFFFF; bg_b[2] = 16'hFFFF;

    // All-zero inputs give zero outputs (R1, R2).
    full_check(16'h0000, 16'h0000, 1'b0);

    // R3: full-width propagate chains.
    for (int c = 0; c < 2; c++) begin
      apply(16'h5A5A, 16'hA5A5, c[0]);
      check("R3 sum", {16'h0, sum}, {16'h0, {W{~c[0]}}});
      check("R3 cout", {31'h0, cout}, {31'h0, c[0]});
      apply(16'hFFFF, 16'h0000, c[0]);
      check("R3 sum", {16'h0, sum}, {16'h0, {W{~c[0]}}});
      check("R3 cout", {31'h0, cout}, {31'h0, c[0]});
    end

    // R7: extremes.
    apply(16'hFFFF, 16'hFFFF, 1'b1);
    check("R7 sum", {16'h0, sum}, 32'h0000_FFFF);
    check("R7 cout", {31'h0, cout}, 32'h1);
    apply(16'hFFFF, 16'hFFFF, 1'b0);
    check("R7 sum", {16'h0, sum}, 32'h0000_FFFE);
    check("R7 cout", {31'h0, cout}, 32'h1);

    // R5: generate / kill of one slice, other slices zero.
    for (int k = 0; k < 4; k++)
      for (int an = 0; an < 16; an++)
        for (int bn = 0; bn < 16; bn++)
          for (int c = 0; c < 2; c++) begin
            av = W'(an) << (4 * k);
            bv = W'(bn) << (4 * k);
            apply(av, bv, c[0]);
            check("R5 group carry", {31'h0, carry_after(k)},
                  {31'h0, ((an + bn + ((k == 0) ? c : 0)) >= 16)});
          end

    // R6: propagate-only slice passes the carry built below it.
    for (int k = 0; k < 4; k++)
      for (int an = 0; an < 16; an++)
        for (int c = 0; c < 2; c++) begin
          keep = (W'(1) << (4 * k)) - 1'b1;
          av = (W'(an) << (4 * k)) | keep;
          bv = W'(an ^ 15) << (4 * k);
          apply(av, bv, c[0]);
          check("R6 group propagate", {31'h0, carry_after(k)}, {31'h0, c[0]});
        end

    // Per-slice exhaustive sweep over three backgrounds (R1, R2, R4).
    for (int k = 0; k < 4; k++)
      for (int g = 0; g < 3; g++)
        for (int an = 0; an < 16; an++)
          for (int bn = 0; bn < 16; bn++)
            for (int c = 0; c < 2; c++) begin
              keep = ~(W'(15) << (4 * k));
              av = (bg_a[g] & keep) | (W'(an) << (4 * k));
              bv = (bg_b[g] & keep) | (W'(bn) << (4 * k));
              full_check(av, bv, c[0]);
            end

    // Random operands (R1, R2, R4).
    for (int i = 0; i < 20000; i++)
      full_check(W'($urandom), W'($urandom), 1'($urandom));

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: run did not finish actual=timeout expected=done");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule